// File: doc/BRIEF.md
# Strobe Bus to APB Bridge

This block connects a lightweight register-bus master to a single APB completer. The master side has no request/acknowledge handshake. The master places an address and write data on the bus and raises a read strobe or a write strobe for one clock cycle. The master then waits while the bridge's ready level is low.

For every accepted strobe, the bridge runs one complete APB transfer. The transfer has a setup cycle and then an access phase, and the completer can stretch the access phase with wait states. The bridge holds every request signal steady until the completer signals completion. At that point the bridge returns read data to the master and reports any completer error through a sticky flag. The flag stays set until the master clears it.

Top module: `strobe_apb_bridge`

## Requirements
- R1: When hostReady is high and a strobe is high on a rising edge, the next cycle shows psel=1 and penable=0 (setup phase). In that cycle paddr and pwdata equal the hostAddr and hostWdata values that were present with the strobe.
- R2: The cycle after setup has psel=1 and penable=1 (access phase). The access phase lasts until pready is sampled high. After that, psel and penable return to 0.
- R3: hostReady is high when idle. It goes low in the cycle after a strobe is accepted and returns high in the cycle after the edge where pready was sampled high in the access phase.
- R4: While an access phase is stalled by pready=0, the signals psel, penable, paddr, pwrite and pwdata keep their values from one cycle to the next.
- R5: pwrite is 1 for a transfer started by the write strobe and 0 for one started by the read strobe. If both strobes are high together, the transfer is a write.
- R6: pstrb is all ones during a write transfer and all zeros during a read transfer. pprot always equals the PROT_VAL parameter.
- R7: After a read completes, hostRdata takes the prdata value sampled on the completing edge, starting in the same cycle that hostReady returns high. Write transfers and idle cycles leave hostRdata unchanged.
- R8: A strobe that arrives while hostReady is low has no effect. No extra transfer follows, and the captured address is not replaced.
- R9: errFlag is set when a transfer completes with pslverr=1, and it stays set afterwards. A high errClear resets it on the next edge. If a completion with error and errClear fall on the same edge, the flag is set.
- R10: During reset and right after it: psel=0, penable=0, hostReady=1, errFlag=0 and hostRdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | ADDR_W | Master address |
| hostWdata | input | DATA_W | Master write data |
| hostRdStb | input | 1 | One-cycle read strobe |
| hostWrStb | input | 1 | One-cycle write strobe |
| hostRdata | output | DATA_W | Data returned by the last completed read |
| hostReady | output | 1 | High when a new strobe can be taken |
| errClear | input | 1 | Clears the sticky error flag |
| errFlag | output | 1 | Sticky completer error indication |
| paddr | output | ADDR_W | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB direction, 1 for write |
| pwdata | output | DATA_W | APB write data |
| pstrb | output | DATA_W/8 | APB byte-lane enables |
| pprot | output | 3 | APB protection attribute |
| pready | input | 1 | APB completer ready |
| prdata | input | DATA_W | APB read data |
| pslverr | input | 1 | APB completer error |

## Verification
The bench drives random transfers with random wait-state counts, random data and random error responses. It also includes directed cases: zero-wait completion, simultaneous read and write strobes, strobes arriving while busy, and error clear on the same edge as an error completion.

- A bridge that skipped setup would show penable high in the first busy cycle.
- A bridge that re-captured inputs while busy would move paddr during wait states or start an extra transfer.
- A bridge that gave priority to the read strobe would show pwrite low.
- A bridge that let writes disturb hostRdata, or let clear beat a new error, would return the wrong value after completion.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;       // latch request fields this edge
    logic captureWrite;  // direction of the captured request
    logic complete;      // access phase finishes this edge
  } ctrlStb_t;
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostRdStb,
  input  logic     hostWrStb,
  input  logic     pready,
  output ctrlStb_t ctrlStb,
  output logic     psel,
  output logic     penable,
  output logic     hostReady
);
  bridgeState_t state, stateNext;

  always_comb begin
    ctrlStb.capture      = (state == ST_IDLE) && (hostRdStb || hostWrStb);
    ctrlStb.captureWrite = hostWrStb;
    ctrlStb.complete     = (state == ST_ACCESS) && pready;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (hostRdStb || hostWrStb) stateNext = ST_SETUP;
      ST_SETUP:  stateNext = ST_ACCESS;
      ST_ACCESS: if (pready) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign psel      = (state != ST_IDLE);
  assign penable   = (state == ST_ACCESS);
  assign hostReady = (state == ST_IDLE);
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          ctrlStb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  input  logic              errClear,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  output logic              pwrite,
  output logic [STRB_W-1:0] pstrb,
  output logic [DATA_W-1:0] hostRdata,
  output logic              errFlag
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;
  logic [DATA_W-1:0] rdataQ;
  logic              errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (ctrlStb.capture) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
      writeQ <= ctrlStb.captureWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             rdataQ <= '0;
    else if (ctrlStb.complete && !writeQ)  rdataQ <= prdata;
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              errQ <= 1'b0;
    else if (ctrlStb.complete && pslverr)   errQ <= 1'b1;
    else if (errClear)                      errQ <= 1'b0;
  end

  generate
    for (genvar lane = 0; lane < STRB_W; lane++) begin : gLane
      assign pstrb[lane] = writeQ;
    end
  endgenerate

  assign paddr     = addrQ;
  assign pwdata    = wdataQ;
  assign pwrite    = writeQ;
  assign hostRdata = rdataQ;
  assign errFlag   = errQ;
endmodule

// File: rtl/strobe_apb_bridge.sv
module strobe_apb_bridge
  import bridge_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         DATA_W   = 32,
  parameter logic [2:0] PROT_VAL = 3'b010,
  localparam int        STRB_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostRdStb,
  input  logic              hostWrStb,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostReady,
  input  logic              errClear,
  output logic              errFlag,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [2:0]        pprot,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  ctrlStb_t ctrlStb;

  bridge_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostRdStb (hostRdStb),
    .hostWrStb (hostWrStb),
    .pready    (pready),
    .ctrlStb   (ctrlStb),
    .psel      (psel),
    .penable   (penable),
    .hostReady (hostReady)
  );

  bridge_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlStb   (ctrlStb),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .prdata    (prdata),
    .pslverr   (pslverr),
    .errClear  (errClear),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pwrite    (pwrite),
    .pstrb     (pstrb),
    .hostRdata (hostRdata),
    .errFlag   (errFlag)
  );

  assign pprot = PROT_VAL;
endmodule

// File: rtl/strobe_apb_bridge_checker.sv
module strobe_apb_bridge_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostRdStb,
  input logic              hostWrStb,
  input logic              hostReady,
  input logic              errFlag,
  input logic [ADDR_W-1:0] paddr,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [DATA_W-1:0] pwdata,
  input logic [STRB_W-1:0] pstrb,
  input logic              pready,
  input logic              pslverr
);
  assert_accept_setup_R1: assert property (@(posedge clk) disable iff (!rstN)
    hostReady && (hostRdStb || hostWrStb) |=> psel && !penable);

  assert_setup_to_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    psel && !penable |=> psel && penable);

  assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    psel |-> !hostReady);

  assert_hold_during_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    psel && penable && !pready |=> psel && penable && $stable(paddr)
      && $stable(pwrite) && $stable(pwdata));

  assert_write_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostReady && hostWrStb |=> pwrite);

  assert_read_no_lanes_R6: assert property (@(posedge clk) disable iff (!rstN)
    psel && !pwrite |-> pstrb == '0);

  assert_error_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    psel && penable && pready && pslverr |=> errFlag);
endmodule

bind strobe_apb_bridge strobe_apb_bridge_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .hostRdStb (hostRdStb),
  .hostWrStb (hostWrStb),
  .hostReady (hostReady),
  .errFlag   (errFlag),
  .paddr     (paddr),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .pwdata    (pwdata),
  .pstrb     (pstrb),
  .pready    (pready),
  .pslverr   (pslverr)
);

// File: tb/tb_strobe_apb_bridge.sv
module tb_strobe_apb_bridge;
  localparam int         CLK_PERIOD = 10;
  localparam int         ADDR_W     = 12;
  localparam int         DATA_W     = 32;
  localparam int         STRB_W     = DATA_W / 8;
  localparam logic [2:0] PROT       = 3'b101;
  localparam int         WATCHDOG   = 50000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic              hostRdStb = 1'b0, hostWrStb = 1'b0;
  logic [DATA_W-1:0] hostRdata;
  logic              hostReady;
  logic              errClear = 1'b0;
  logic              errFlag;
  logic [ADDR_W-1:0] paddr;
  logic              psel, penable, pwrite;
  logic [DATA_W-1:0] pwdata;
  logic [STRB_W-1:0] pstrb;
  logic [2:0]        pprot;
  logic              pready = 1'b0;
  logic [DATA_W-1:0] prdata = '0;
  logic              pslverr = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] expRdata = '0;
  logic              expErr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_apb_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_VAL(PROT)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdStb(hostRdStb), .hostWrStb(hostWrStb), .hostRdata(hostRdata),
    .hostReady(hostReady), .errClear(errClear), .errFlag(errFlag),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .pready(pready),
    .prdata(prdata), .pslverr(pslverr)
  );

  function automatic logic [STRB_W-1:0] lanesFor(input logic isWrite);
    return isWrite ? '1 : '0;
  endfunction

  function automatic logic nextErr(input logic cur, input logic hit, input logic clr);
    if (hit) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one full transfer; stray strobe optionally hits while busy
  task automatic runXfer(input logic doWr, input logic doRd,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input int waits, input logic [DATA_W-1:0] rd,
                         input logic err, input logic stray, input logic clrEnd);
    logic isW;
    isW = doWr;
    @(negedge clk);
    chk(hostReady === 1'b1, "R3", "ready before strobe", 64'(hostReady), 64'd1);
    hostAddr = a; hostWdata = d; hostWrStb = doWr; hostRdStb = doRd;
    @(negedge clk);
    hostWrStb = 1'b0; hostRdStb = 1'b0;
    if (stray) begin
      hostAddr = ~a; hostWdata = ~d; hostWrStb = 1'b1; hostRdStb = 1'b1;
    end
    chk(psel === 1'b1 && penable === 1'b0, "R1", "setup phase",
        64'({psel, penable}), 64'b10);
    chk(paddr === a && (!isW || pwdata === d), "R1", "captured addr",
        64'(paddr), 64'(a));
    chk(hostReady === 1'b0, "R3", "ready low in setup", 64'(hostReady), 64'd0);
    chk(pwrite === isW, "R5", "direction", 64'(pwrite), 64'(isW));
    chk(pstrb === lanesFor(isW) && pprot === PROT, "R6", "lanes and prot",
        64'({pstrb, pprot}), 64'({lanesFor(isW), PROT}));
    @(negedge clk);
    hostWrStb = 1'b0; hostRdStb = 1'b0;
    chk(psel === 1'b1 && penable === 1'b1, "R2", "access phase",
        64'({psel, penable}), 64'b11);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(psel === 1'b1 && penable === 1'b1 && paddr === a && pwrite === isW
          && (!isW || pwdata === d), "R4", "held during wait",
          64'(paddr), 64'(a));
      chk(hostReady === 1'b0, "R8", "stray strobe ignored while busy",
          64'(hostReady), 64'd0);
    end
    pready = 1'b1; prdata = rd; pslverr = err; errClear = clrEnd;
    @(negedge clk);
    pready = 1'b0; pslverr = 1'b0; errClear = 1'b0; prdata = ~rd;
    if (!isW) expRdata = rd;
    expErr = nextErr(expErr, err, clrEnd);
    chk(psel === 1'b0 && penable === 1'b0, "R2", "idle after completion",
        64'({psel, penable}), 64'b0);
    chk(hostReady === 1'b1, "R3", "ready back", 64'(hostReady), 64'd1);
    chk(hostRdata === expRdata, "R7", "read data", 64'(hostRdata), 64'(expRdata));
    chk(errFlag === expErr, "R9", "error flag", 64'(errFlag), 64'(expErr));
    if (stray) begin
      @(negedge clk);
      chk(psel === 1'b0 && paddr === a, "R8", "no transfer from stray strobe",
          64'(paddr), 64'(a));
    end
  endtask

  task automatic mainSeq();
    // R10 reset state
    #(CLK_PERIOD * 2 + 1);
    chk(psel === 1'b0 && penable === 1'b0 && hostReady === 1'b1 && errFlag === 1'b0
        && hostRdata === '0, "R10", "state in reset",
        64'({psel, penable, hostReady, errFlag}), 64'b0010);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(psel === 1'b0 && hostReady === 1'b1, "R10", "state after reset",
        64'({psel, hostReady}), 64'b01);

    // directed corners
    runXfer(1'b0, 1'b1, 12'h123, 32'h0, 0, 32'hCAFE_0001, 1'b0, 1'b0, 1'b0);
    runXfer(1'b1, 1'b0, 12'h456, 32'hDEAD_BEEF, 3, 32'h1111_2222, 1'b0, 1'b0, 1'b0);
    runXfer(1'b1, 1'b1, 12'h789, 32'h5555_AAAA, 1, 32'h0, 1'b0, 1'b0, 1'b0); // R5 both strobes
    runXfer(1'b0, 1'b1, 12'hABC, 32'h0, 2, 32'h0BAD_F00D, 1'b1, 1'b1, 1'b0); // R8 stray, R9 error
    // R9 sticky across an error-free transfer
    runXfer(1'b0, 1'b1, 12'h010, 32'h0, 0, 32'h7777_0000, 1'b0, 1'b0, 1'b0);
    // R9 clear
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0; expErr = 1'b0;
    chk(errFlag === 1'b0, "R9", "cleared", 64'(errFlag), 64'd0);
    // R9 set wins over simultaneous clear
    runXfer(1'b1, 1'b0, 12'h020, 32'h1234_5678, 1, 32'h0, 1'b1, 1'b0, 1'b1);

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 80; n++) begin
      logic wr, rd2, e, s, c;
      int wt;
      wr  = 1'($urandom());
      rd2 = wr ? 1'($urandom()) : 1'b1;
      e   = ($urandom_range(0, 3) == 0);
      s   = ($urandom_range(0, 4) == 0);
      c   = ($urandom_range(0, 3) == 0);
      wt  = $urandom_range(0, 4);
      runXfer(wr, rd2, ADDR_W'($urandom()), $urandom(), wt, $urandom(), e, s, c);
    end
  endtask

  initial begin
    logic timedOut;
    timedOut = 1'b0;
    fork
      mainSeq();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule